// File: doc/BRIEF.md
# NAND Bank Reset and Presence Detector

This engine sits on the controller side of a multi-bank NAND flash interface. Software resets the flash device behind one chip select by writing a one-hot bank mask. The engine then selects that bank, issues the Reset command and watches the shared ready/busy line. It ends the operation in one of three ways: the device signals ready, the line never goes busy, or a programmable timeout expires. It then posts per-bank status flags.

The completion flag and the timeout flag are raised whether or not a device is fitted. Presence is therefore shown by a separate activity flag. That flag is set only when ready/busy was seen to fall and then rise during the operation.

An auto-scan command resets the banks one after another in ascending order. The scan stops at the first bank that shows no activity, and that bank's index is published as the number of connected chips. All status flags are wiped when the scan starts and again when it ends.

Top module: `nand_bank_reset`

## Requirements
- R1: After reset, busy is 0, every chip-select output is high (inactive), cmd_valid is 0, every bank status reads 0, the chip count reads 0 and the timeout limit reads its default value (1000).
- R2: A write to address 0 with a one-hot mask in which bit i is set starts a reset of bank i. The engine holds ce_n[i] low (and only that bit) while busy, and it pulses cmd_valid for one cycle with cmd_byte = 0xFF. Reading address 0 returns busy in bit 0.
- R3: When ready/busy falls and then rises after the command, the bank's status (address 4+i) gets bit 0 (complete) and bit 2 (activity) set, bit 1 stays clear, and busy returns to 0.
- R4: When ready/busy stays high for 8 cycles after the command, the operation ends with bit 0 (complete) set and bit 2 (activity) clear.
- R5: When ready/busy goes low and does not return high within the timeout limit, the bank's bit 1 (timeout) is set, with bits 0 and 2 clear.
- R6: The timeout limit, in clock cycles counted from the command, is written and read at address 2. An operation held busy ends no earlier than the limit and at most a few cycles after it.
- R7: Status bits are write-one-to-clear. A write to address 4+i clears only the bits written as 1.
- R8: A reset request written while the engine is busy is ignored, and so is a mask that is zero or has more than one bit set. Neither starts a command.
- R9: Writing 1 to bit 0 of address 1 while idle starts a scan. Banks are reset one at a time in ascending order, each waiting for its end before the next starts. The scan stops after the first bank without activity, and address 1 then reads that bank's index, or the bank count if every bank shows activity.
- R10: All bank status flags are cleared when a scan starts and again when it finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr (combinational) |
| busy | output | 1 | A reset or scan is in progress |
| ce_n | output | NBANK | Active-low chip selects, one per bank |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte (Reset, 0xFF) |
| rb_n | input | 1 | Asynchronous shared ready/busy line, low = busy |

## Verification
Single resets are tried against three device behaviours: a device that toggles ready/busy, a bank with no device where the line stays high, and a device that stays busy past the limit. These show that only a real toggle raises the activity flag, while the other two cases end on the complete flag and the timeout flag respectively. Scans are run with a gap in the middle of the population, with every bank fitted and with bank 0 empty. This separates the stop-at-first-gap rule and the count value from a scan that runs over all banks. The command log shows the ascending order of the resets. Rejected requests, both a busy-time write and a mask that is not one-hot, are checked through the command log and the status registers.

// File: rtl/nand_bank_reset.sv
module nand_bank_reset #(
  parameter int NBANK   = 4,
  parameter int TW      = 16,
  parameter int TMO_DEF = 1000,
  parameter int GUARD   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             busy,
  output logic [NBANK-1:0] ce_n,
  output logic             cmd_valid,
  output logic [7:0]       cmd_byte,
  input  logic             rb_n
);
  localparam int BW = $clog2(NBANK);
  localparam int CW = $clog2(NBANK + 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  logic [1:0]             rb_sync;
  logic [BW-1:0]          bank, enc;
  logic                   scan, fell;
  logic [CW-1:0]          count;
  logic [TW-1:0]          tmo_lim, cnt;
  logic [NBANK-1:0][2:0]  stat;
  logic [3:0]             sidx;

  wire rb_s       = rb_sync[1];
  wire end_act    = st == S_WAIT && fell && rb_s;
  wire end_nochip = st == S_WAIT && !fell && rb_s && cnt == TW'(GUARD - 1);
  wire end_tmo    = st == S_WAIT && !end_act && !end_nochip && cnt == tmo_lim - TW'(1);
  wire op_end     = end_act | end_nochip | end_tmo;
  wire req_ok     = wr_en && addr == 4'd0 && st == S_IDLE &&
                    $onehot(wdata[NBANK-1:0]) && wdata[31:NBANK] == '0;
  wire scan_go    = wr_en && addr == 4'd1 && wdata[0] && st == S_IDLE;
  assign sidx     = addr - 4'd4;
  wire stat_sel   = addr >= 4'd4 && int'(sidx) < NBANK;

  always_comb begin
    enc = '0;
    for (int i = 0; i < NBANK; i++) if (wdata[i]) enc = BW'(i);
  end

  assign busy      = st != S_IDLE;
  assign ce_n      = busy ? ~(NBANK'(1) << bank) : '1;
  assign cmd_valid = st == S_ISSUE;
  assign cmd_byte  = 8'hFF;

  always_comb begin
    rdata = '0;
    if (addr == 4'd0)      rdata[0] = busy;
    else if (addr == 4'd1) rdata[CW-1:0] = count;
    else if (addr == 4'd2) rdata[TW-1:0] = tmo_lim;
    else if (stat_sel)     rdata[2:0] = stat[sidx[BW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rb_sync <= 2'b11; bank <= '0; scan <= 1'b0; fell <= 1'b0;
      count <= '0; tmo_lim <= TW'(TMO_DEF); cnt <= '0; stat <= '0;
    end else begin
      rb_sync <= {rb_sync[0], rb_n};
      if (wr_en && addr == 4'd2) tmo_lim <= wdata[TW-1:0];
      if (wr_en && stat_sel) stat[sidx[BW-1:0]] <= stat[sidx[BW-1:0]] & ~wdata[2:0];
      case (st)
        S_IDLE:
          if (req_ok) begin
            bank <= enc; st <= S_ISSUE;
          end else if (scan_go) begin
            bank <= '0; scan <= 1'b1; stat <= '0; st <= S_ISSUE;
          end
        S_ISSUE: begin
          cnt <= '0; fell <= 1'b0; st <= S_WAIT;
        end
        default: begin
          cnt <= cnt + TW'(1);
          if (!rb_s) fell <= 1'b1;
          if (op_end) begin
            stat[bank] <= stat[bank] | {end_act, end_tmo, end_act | end_nochip};
            st <= S_IDLE;
            if (scan) begin
              if (end_act && int'(bank) != NBANK - 1) begin
                bank <= bank + BW'(1); st <= S_ISSUE;
              end else begin
                count <= end_act ? CW'(bank) + CW'(1) : CW'(bank);
                stat <= '0; scan <= 1'b0;
              end
            end
          end
        end
      endcase
    end
  end

  p_single_ce_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ce_n));
  p_cmd_one_bank_r2: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> $onehot(~ce_n));
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !scan && !op_end && wr_en && addr == 4'd0) |=> $stable(ce_n));
  p_scan_clear_r10: assert property (@(posedge clk) disable iff (!rst_n) $fell(scan) |-> stat == '0);
  p_count_range_r9: assert property (@(posedge clk) disable iff (!rst_n) int'(count) <= NBANK);
  for (genvar g = 0; g < NBANK; g++) begin : g_chk
    p_act_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[g][2]) |-> stat[g][0]);
    p_tmo_no_act_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[g][1]) |-> !$rose(stat[g][2]));
  end
endmodule

// File: tb/tb_nand_bank_reset.sv
`timescale 1ns/1ps
module tb_nand_bank_reset;
  localparam int NB = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rb_n = 1;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic busy, cmd_valid;
  logic [NB-1:0] ce_n;
  logic [7:0] cmd_byte;
  int errors = 0, checks = 0;
  logic [NB-1:0] present = '0;
  int hold = 20, nlog = 0, chip_busy = 0;
  int logb [16];

  always #4 clk = ~clk;

  nand_bank_reset #(.NBANK(NB)) dut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
    .busy, .ce_n, .cmd_valid, .cmd_byte, .rb_n);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  // device model: sampled on falling edges
  initial forever begin
    @(negedge clk);
    if (cmd_valid) begin
      int b = -1;
      for (int i = 0; i < NB; i++) if (!ce_n[i]) b = i;
      if (nlog < 16) logb[nlog] = b;
      nlog++;
      chk(cmd_byte == 8'hFF, "R2 cmd byte", cmd_byte, 255);
      if (b >= 0 && present[b]) begin
        chip_busy = 1;
        repeat (3) @(negedge clk);
        rb_n = 0;
        repeat (hold) @(negedge clk);
        rb_n = 1;
        chip_busy = 0;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask
  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy || chip_busy != 0) begin @(negedge clk); cyc++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ce_n == '1, "R1 ce_n", ce_n, 15);
    chk(cmd_valid == 0, "R1 cmd_valid", cmd_valid, 0);
    rd(1, d); chk(d == 0, "R1 count", d, 0);
    rd(2, d); chk(d == 1000, "R1 timeout default", d, 1000);
    for (int i = 0; i < NB; i++) begin rd(4'(4 + i), d); chk(d == 0, "R1 status", d, 0); end
  endtask

  task automatic t_present;
    logic [31:0] d; int c, n0;
    present = 4'b0100; hold = 20; n0 = nlog;
    wr(0, 32'h4);
    chk(ce_n == 4'b1011, "R2 ce_n during op", ce_n, 11);
    rd(0, d); chk(d[0] == 1, "R2 busy readable", d, 1);
    wait_idle(c);
    chk(nlog == n0 + 1 && logb[n0] == 2, "R2 one command on bank 2", logb[n0], 2);
    rd(6, d); chk(d == 32'h5, "R3 done+act", d, 5);
    chk(busy == 0 && ce_n == '1, "R3 idle after", busy, 0);
  endtask

  task automatic t_absent;
    logic [31:0] d; int c;
    present = 0;
    wr(0, 32'h1); wait_idle(c);
    rd(4, d); chk(d == 32'h1, "R4 done no act", d, 1);
  endtask

  task automatic t_timeout;
    logic [31:0] d; int c;
    present = 4'b0010; hold = 100;
    wr(2, 40); rd(2, d); chk(d == 40, "R6 limit readback", d, 40);
    wr(0, 32'h2);
    c = 0; while (busy) begin @(negedge clk); c++; end
    chk(c >= 38 && c <= 46, "R6 timeout duration", c, 40);
    rd(5, d); chk(d == 32'h2, "R5 timeout only", d, 2);
    wait_idle(c); hold = 20; wr(2, 1000);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    rd(6, d); chk(d == 5, "R7 pre", d, 5);
    wr(6, 32'h4); rd(6, d); chk(d == 1, "R7 clear act only", d, 1);
    wr(6, 32'h0); rd(6, d); chk(d == 1, "R7 zero write no effect", d, 1);
    wr(6, 32'h1); rd(6, d); chk(d == 0, "R7 clear done", d, 0);
    wr(5, 32'h7); wr(4, 32'h7);
  endtask

  task automatic t_ignore;
    logic [31:0] d; int c, n0;
    present = 4'b0001; hold = 20; n0 = nlog;
    wr(0, 32'h1);
    wr(0, 32'h8);
    wait_idle(c);
    chk(nlog == n0 + 1, "R8 busy request ignored", nlog - n0, 1);
    rd(7, d); chk(d == 0, "R8 bank3 untouched", d, 0);
    wr(4, 32'h7);
    n0 = nlog;
    wr(0, 32'h3); chk(busy == 0, "R8 multi-bit mask ignored", busy, 0);
    wr(0, 32'h0); chk(busy == 0, "R8 zero mask ignored", busy, 0);
    repeat (4) @(negedge clk);
    chk(nlog == n0, "R8 no command", nlog - n0, 0);
  endtask

  task automatic t_scan(input logic [NB-1:0] pop, input int exp_cnt);
    logic [31:0] d; int c, n0;
    present = 4'b0001; hold = 20; wr(0, 32'h1); wait_idle(c);
    rd(4, d); chk(d == 5, "R10 pre-scan flag set", d, 5);
    present = pop; n0 = nlog;
    wr(1, 32'h1);
    @(negedge clk); #1;
    rd(4, d); chk(d == 0, "R10 flags cleared at start", d, 0);
    wait_idle(c);
    rd(1, d); chk(d == exp_cnt, "R9 count", d, exp_cnt);
    chk(nlog - n0 == ((exp_cnt < NB) ? exp_cnt + 1 : NB), "R9 resets issued", nlog - n0, exp_cnt + 1);
    for (int i = 0; i < nlog - n0 && i < NB; i++)
      chk(logb[n0 + i] == i, "R9 ascending order", logb[n0 + i], i);
    for (int i = 0; i < NB; i++) begin rd(4'(4 + i), d); chk(d == 0, "R10 flags cleared at end", d, 0); end
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_present;
    t_absent;
    t_timeout;
    t_w1c;
    t_ignore;
    t_scan(4'b1011, 2);
    t_scan(4'b1111, 4);
    t_scan(4'b1110, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule